// File: doc/BRIEF.md
# Timer-Based Auxiliary PWM Generator

This block is a 32-bit time-stamp counter that can act as a single-output PWM source. Software programs it through a simple write/read register port: a 16-bit mode word, the counter itself, and four 32-bit capture slots. When the auxiliary-PWM mode bit is set, the third and fourth slots stop being plain storage. A write to either one lands in a shadow copy of the period limit or the compare level. The running waveform only picks up the new values when the counter rolls over, so a period never ends up with mixed settings.

The counter advances by one per clock while its run bit is set. In PWM mode it returns to zero on the clock after it reaches the active limit. The programmed limit is the wanted period length minus one. The output is a registered flag that is high while the counter sits below the active compare level. Software restarts a period by writing zero to the counter. With PWM mode off, the unit is a plain free-running 32-bit counter with directly loaded slots and a low output.

Top module: `apwm_timer`

## Requirements
- R1: After reset the counter, the mode word, all four slots and both shadow copies read as zero, and `pwmOut` is low.
- R2: A write to offset 0x2A stores `wrData[15:0]` as the mode word, and reading 0x2A returns it zero-extended. Bit 9 selects PWM mode and bit 4 enables counting. All other bits, including the all-ones sync field in bits 7:6, are only stored.
- R3: While bit 4 of the mode word is clear, the counter keeps its value unless it is written.
- R4: A write to offset 0x00 loads the counter with `wrData` on the next edge. Writing zero restarts the count. The write takes priority over counting and rollover, and it suppresses the shadow transfer for that cycle.
- R5: In PWM mode with counting enabled, a counter value at or above the active limit is followed by zero. Any lower value is followed by itself plus one.
- R6: In PWM mode, writes to 0x10 (limit) and 0x14 (compare) change only the shadows. Reads of 0x10 and 0x14 return the active values. The shadows move to the active registers on the rollover edge of R5, and a shadow written in that same cycle is applied at the next rollover.
- R7: With PWM mode off, writes to 0x10 and 0x14 load both the shadow and the active register at once.
- R8: In PWM mode, `pwmOut` in a given cycle equals (counter < active compare) as it stood one cycle earlier. A compare of zero therefore gives a constant low output, and a compare above the limit gives a constant high output.
- R9: With PWM mode off, `pwmOut` is low, and a running counter steps by one and wraps from 0xFFFFFFFF to zero.
- R10: Offsets 0x08 and 0x0C are plain 32-bit storage that reads back as written. Reads of any unmapped offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 6 | Byte offset of the write |
| wrData | input | 32 | Write data |
| rdAddr | input | 6 | Byte offset of the combinational read |
| rdData | output | 32 | Read data for `rdAddr` |
| pwmOut | output | 1 | Registered PWM output |

## Verification
The assertions take for granted that at most one register is written per cycle and that the write offset is stable around the clock edge. Under that assumption every write turns into a single strobe, which is what the strobe check relies on. The constant-high check also assumes the counter is not above the limit, since a counter loaded above the limit sits outside the compare relation for one cycle. The stimulus issues one write per cycle at most. It keeps limits and compare levels small so that rollovers and shadow transfers happen often, and it mixes counter writes, mode switches and stop periods with directed cases: the all-ones wrap, a compare of zero, and a compare above the limit.

// File: rtl/apwm_pkg.sv
package apwm_pkg;
  localparam int DATA_W   = 32;
  localparam int CTRL_W   = 16;
  localparam int ADDR_W   = 6;
  localparam int MODE_BIT = 9;
  localparam int RUN_BIT  = 4;

  localparam logic [ADDR_W-1:0] OFS_CNT  = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_CAP1 = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_CAP2 = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_PRD  = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_CMP  = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 6'h2A;

  // strobes from the decoder to the datapath
  typedef struct packed {
    logic              cntLoad;
    logic              cap1Wr;
    logic              cap2Wr;
    logic              prdShWr;
    logic              prdDirWr;
    logic              cmpShWr;
    logic              cmpDirWr;
    logic              runEn;
    logic              pwmMode;
    logic [DATA_W-1:0] wrVal;
  } strobe_t;
endpackage

// File: rtl/apwm_ctrl.sv
module apwm_ctrl
  import apwm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [CTRL_W-1:0] ctrlWord,
  output strobe_t           stb
);
  logic hitCnt, hitPrd, hitCmp, hitCtrl;

  always_comb begin
    hitCnt  = wrEn && (wrAddr == OFS_CNT);
    hitPrd  = wrEn && (wrAddr == OFS_PRD);
    hitCmp  = wrEn && (wrAddr == OFS_CMP);
    hitCtrl = wrEn && (wrAddr == OFS_CTRL);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        ctrlWord <= '0;
    else if (hitCtrl) ctrlWord <= wrData[CTRL_W-1:0];
  end

  always_comb begin
    stb.pwmMode  = ctrlWord[MODE_BIT];
    stb.runEn    = ctrlWord[RUN_BIT];
    stb.cntLoad  = hitCnt;
    stb.cap1Wr   = wrEn && (wrAddr == OFS_CAP1);
    stb.cap2Wr   = wrEn && (wrAddr == OFS_CAP2);
    stb.prdShWr  = hitPrd && ctrlWord[MODE_BIT];
    stb.prdDirWr = hitPrd && !ctrlWord[MODE_BIT];
    stb.cmpShWr  = hitCmp && ctrlWord[MODE_BIT];
    stb.cmpDirWr = hitCmp && !ctrlWord[MODE_BIT];
    stb.wrVal    = wrData;
  end

  // R2
  ctrl_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == OFS_CTRL) |=> ctrlWord == $past(wrData[CTRL_W-1:0]));

  // R4
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.cntLoad, stb.cap1Wr, stb.cap2Wr, stb.prdShWr,
              stb.prdDirWr, stb.cmpShWr, stb.cmpDirWr}));
endmodule

// File: rtl/apwm_dp.sv
module apwm_dp
  import apwm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  output logic [DATA_W-1:0] cntQ,
  output logic [DATA_W-1:0] cap1Q,
  output logic [DATA_W-1:0] cap2Q,
  output logic [DATA_W-1:0] prdAct,
  output logic [DATA_W-1:0] cmpAct,
  output logic              pwmQ
);
  logic [DATA_W-1:0] prdSh, cmpSh;
  logic atEnd, wrapNow;

  always_comb begin
    atEnd   = cntQ >= prdAct;
    wrapNow = stb.runEn && stb.pwmMode && !stb.cntLoad && atEnd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cntQ <= '0;
    else if (stb.cntLoad) cntQ <= stb.wrVal;
    else if (wrapNow)     cntQ <= '0;
    else if (stb.runEn)   cntQ <= cntQ + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prdSh  <= '0;
      prdAct <= '0;
      cmpSh  <= '0;
      cmpAct <= '0;
    end else begin
      if (wrapNow) begin
        prdAct <= prdSh;
        cmpAct <= cmpSh;
      end
      if (stb.prdShWr || stb.prdDirWr) prdSh  <= stb.wrVal;
      if (stb.prdDirWr)                prdAct <= stb.wrVal;
      if (stb.cmpShWr || stb.cmpDirWr) cmpSh  <= stb.wrVal;
      if (stb.cmpDirWr)                cmpAct <= stb.wrVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cap1Q <= '0;
      cap2Q <= '0;
      pwmQ  <= 1'b0;
    end else begin
      if (stb.cap1Wr) cap1Q <= stb.wrVal;
      if (stb.cap2Wr) cap2Q <= stb.wrVal;
      pwmQ <= stb.pwmMode && (cntQ < cmpAct);
    end
  end

  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.runEn && !stb.cntLoad) |=> $stable(cntQ));

  // R4
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.cntLoad |=> cntQ == $past(stb.wrVal));

  // R5
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.runEn && stb.pwmMode && !stb.cntLoad && cntQ >= prdAct) |=> cntQ == '0);

  // R5
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.runEn && !stb.cntLoad && !(stb.pwmMode && cntQ >= prdAct))
      |=> cntQ == $past(cntQ) + 1'b1);

  // R6
  active_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.pwmMode && (!stb.runEn || stb.cntLoad || cntQ < prdAct))
      |=> ($stable(prdAct) && $stable(cmpAct)));

  // R7
  direct_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.prdDirWr |=> prdAct == $past(stb.wrVal));

  // R8
  cmp_zero_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.pwmMode && cmpAct == '0) |=> !pwmQ);

  // R8
  cmp_above_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.pwmMode && cmpAct > prdAct && cntQ <= prdAct) |=> pwmQ);

  // R9
  capture_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.pwmMode |=> !pwmQ);
endmodule

// File: rtl/apwm_timer.sv
module apwm_timer
  import apwm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              pwmOut
);
  strobe_t           stb;
  logic [CTRL_W-1:0] ctrlWord;
  logic [DATA_W-1:0] cntQ, cap1Q, cap2Q, prdAct, cmpAct;

  apwm_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .ctrlWord (ctrlWord),
    .stb      (stb)
  );

  apwm_dp u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .cntQ   (cntQ),
    .cap1Q  (cap1Q),
    .cap2Q  (cap2Q),
    .prdAct (prdAct),
    .cmpAct (cmpAct),
    .pwmQ   (pwmOut)
  );

  always_comb begin
    case (rdAddr)
      OFS_CNT:  rdData = cntQ;
      OFS_CAP1: rdData = cap1Q;
      OFS_CAP2: rdData = cap2Q;
      OFS_PRD:  rdData = prdAct;
      OFS_CMP:  rdData = cmpAct;
      OFS_CTRL: rdData = {{(DATA_W-CTRL_W){1'b0}}, ctrlWord};
      default:  rdData = '0;
    endcase
  end
endmodule

// File: tb/apwm_timer_tb.sv
`timescale 1ns/1ps
module apwm_timer_tb;
  localparam real CLK_NS = 20.0;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [5:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [5:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic        pwmOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] mCtrl;
  logic [31:0] mCnt, mCap1, mCap2, mPrdSh, mPrdA, mCmpSh, mCmpA;
  logic        mPwm;

  always #(CLK_NS/2) clk = ~clk;

  apwm_timer u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .pwmOut(pwmOut)
  );

  function automatic logic [31:0] mRead(input logic [5:0] a);
    case (a)
      6'h00:   return mCnt;
      6'h08:   return mCap1;
      6'h0C:   return mCap2;
      6'h10:   return mPrdA;
      6'h14:   return mCmpA;
      6'h2A:   return {16'h0, mCtrl};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tagFor(input logic [5:0] a);
    case (a)
      6'h00:        return "R5";
      6'h10, 6'h14: return "R6";
      6'h2A:        return "R2";
      default:      return "R10";
    endcase
  endfunction

  task automatic modelReset();
    mCtrl = '0; mCnt = '0; mCap1 = '0; mCap2 = '0;
    mPrdSh = '0; mPrdA = '0; mCmpSh = '0; mCmpA = '0; mPwm = 1'b0;
  endtask

  task automatic modelUpdate(input logic we, input logic [5:0] wa, input logic [31:0] wd);
    logic mode, run, wrap;
    logic [31:0] nCnt, nPrdA, nCmpA;
    mode = mCtrl[9];
    run  = mCtrl[4];
    wrap = 1'b0;
    nCnt = mCnt; nPrdA = mPrdA; nCmpA = mCmpA;
    mPwm = mode && (mCnt < mCmpA);
    if (we && wa == 6'h00) nCnt = wd;
    else if (run) begin
      if (mode && mCnt >= mPrdA) begin nCnt = '0; wrap = 1'b1; end
      else nCnt = mCnt + 1;
    end
    if (wrap) begin nPrdA = mPrdSh; nCmpA = mCmpSh; end
    if (we) begin
      case (wa)
        6'h08: mCap1 = wd;
        6'h0C: mCap2 = wd;
        6'h10: begin mPrdSh = wd; if (!mode) nPrdA = wd; end
        6'h14: begin mCmpSh = wd; if (!mode) nCmpA = wd; end
        6'h2A: mCtrl = wd[15:0];
        default: ;
      endcase
    end
    mCnt = nCnt; mPrdA = nPrdA; mCmpA = nCmpA;
  endtask

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic we, input logic [5:0] wa, input logic [31:0] wd,
                      input logic [5:0] ra, input string tag);
    @(negedge clk);
    wrEn = we; wrAddr = wa; wrData = wd; rdAddr = ra;
    #1;
    check32(tag, rdData, mRead(ra));
    check32(mCtrl[9] ? "R8" : "R9", {31'h0, pwmOut}, {31'h0, mPwm});
    @(posedge clk);
    modelUpdate(we, wa, wd);
  endtask

  task automatic idle(input int n, input logic [5:0] ra, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 6'h3F, 32'h0, ra, tag);
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1: reset values
    step(1'b0, 6'h3F, 32'h0, 6'h00, "R1");
    step(1'b0, 6'h3F, 32'h0, 6'h2A, "R1");
    step(1'b0, 6'h3F, 32'h0, 6'h14, "R1");
    // R10: plain slots and unmapped reads
    step(1'b1, 6'h08, 32'hDEADBEEF, 6'h08, "R10");
    step(1'b1, 6'h0C, 32'h12345678, 6'h08, "R10");
    step(1'b0, 6'h3F, 32'h0, 6'h0C, "R10");
    step(1'b0, 6'h3F, 32'h0, 6'h20, "R10");
    // R9: capture mode free run and all-ones wrap
    step(1'b1, 6'h2A, 32'hFFFF0010, 6'h2A, "R2");
    idle(4, 6'h00, "R9");
    step(1'b1, 6'h00, 32'hFFFFFFFE, 6'h00, "R4");
    idle(4, 6'h00, "R9");
    // R7: direct load in capture mode
    step(1'b1, 6'h10, 32'd4, 6'h10, "R7");
    step(1'b1, 6'h14, 32'd2, 6'h10, "R7");
    step(1'b0, 6'h3F, 32'h0, 6'h14, "R7");
    // R3: stopped counter holds
    step(1'b1, 6'h2A, 32'h0, 6'h00, "R3");
    idle(5, 6'h00, "R3");
    // R6/R8: PWM mode, restart, shadowed change
    step(1'b1, 6'h2A, 32'h02D0, 6'h2A, "R2");
    step(1'b1, 6'h00, 32'h0, 6'h00, "R4");
    idle(12, 6'h00, "R5");
    step(1'b1, 6'h10, 32'd6, 6'h10, "R6");
    step(1'b1, 6'h14, 32'd3, 6'h10, "R6");
    idle(16, 6'h14, "R6");
    // R8: compare zero gives constant low
    step(1'b1, 6'h14, 32'd0, 6'h14, "R8");
    idle(20, 6'h00, "R8");
    // R8: compare above period gives constant high
    step(1'b1, 6'h14, 32'd9, 6'h14, "R8");
    idle(20, 6'h14, "R8");
    // R4: counter load above limit then rollover
    step(1'b1, 6'h00, 32'd50, 6'h00, "R4");
    idle(4, 6'h00, "R5");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [5:0] wa, ra;
      logic [31:0] wd;
      logic we;
      r = $urandom % 16;
      we = 1'b1;
      case (r)
        0:       begin wa = 6'h00; wd = (($urandom % 2) == 0) ? 32'h0 : ($urandom % 8); end
        1, 2, 3: begin wa = 6'h10; wd = $urandom % 16; end
        4, 5, 6: begin wa = 6'h14; wd = $urandom % 21; end
        7:       begin wa = 6'h2A;
                   wd = {$urandom} & 32'hFFFF_FC2F;
                   if (($urandom % 5) != 0) wd = wd | 32'h200;
                   if (($urandom % 6) != 0) wd = wd | 32'h10;
                   wd = wd | 32'hC0;
                 end
        8:       begin wa = 6'h08; wd = $urandom; end
        9:       begin wa = 6'h0C; wd = $urandom; end
        10:      begin wa = 6'h24; wd = $urandom; end
        default: begin we = 1'b0; wa = 6'h3F; wd = 32'h0; end
      endcase
      case ($urandom % 7)
        0: ra = 6'h00; 1: ra = 6'h08; 2: ra = 6'h0C; 3: ra = 6'h10;
        4: ra = 6'h14; 5: ra = 6'h2A; default: ra = 6'h30;
      endcase
      step(we, wa, wd, ra, tagFor(ra));
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule